// File: doc/BRIEF.md
# Indirect Register Addressing Unit

This unit resolves operand addresses for a small 8-bit register file and performs the access. An instruction names a 7-bit file address and raises a read strobe, a write strobe, or both. A bank-select status bit extends the address. Most file addresses select a storage location directly. One file address is a virtual "indirect" slot with no storage behind it. An access to that slot goes to the location named by an 8-bit pointer register.

The pointer is itself an ordinary location in the register map. Software loads it, reads it back and steps it with normal direct accesses. Indirect accesses can also write it. An indirect access whose pointer names the virtual slot again is a nested access. A nested read returns zero and a nested write is discarded.

The register array is a behavioural memory inside the unit with one synchronous port. Read data, the resolved array address and the array write enable are registered outputs. All three describe the access taken at the previous clock edge.

Top module: `ind_addr_unit`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00, `rf_we` is 0 and the pointer holds 0x00.
- R2: A direct access, with `file_addr` other than 0x00 and 0x04, uses the 9-bit array address {`bank_sel`, 1'b0, `file_addr`}. Read data appears on `rd_data` in the cycle after the read strobe.
- R3: File address 0x04 is the pointer register in either bank. A direct write loads it and a direct read returns it. The pointer changes only when it is written.
- R4: File address 0x00 is the indirect slot. An access to it uses the 9-bit address {`bank_sel`, pointer[7:0]}.
- R5: An indirect read whose pointer has its low 7 bits equal to 0x00 (for example 0x00 or 0x80) returns 0x00.
- R6: An indirect write whose pointer has its low 7 bits equal to 0x00 changes no storage and leaves `rf_we` low in the following cycle.
- R7: An indirect write whose pointer has its low 7 bits equal to 0x04 loads the pointer with the write data. The array is not written.
- R8: A read and a write in the same cycle at the same location return the value held before the write. The new value is visible to the next read.
- R9: `rf_we` is 1 in the cycle after an access that writes the array, and `rf_addr` then shows the 9-bit address written. Array writes never target an address whose low 7 bits are 0x00 or 0x04.
- R10: Set the pointer to 0x40, then repeat three steps until the location at 0x7F has been cleared: write 0x00 indirectly in bank 0, read the pointer back, and write it back plus one. This clears array locations 0x040 to 0x07F and leaves every other location unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| file_addr | input | 7 | File address field of the instruction |
| bank_sel | input | 1 | Bank-select status bit, upper address bit |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data of the previous read |
| rf_addr | output | 9 | Resolved array address of the previous access |
| rf_we | output | 1 | Array write performed at the previous edge |

## Verification
The hardest situations to reach are the indirect accesses that land on the virtual slot or on the pointer itself. Both need the pointer loaded with an exact value through a direct write first. The bench does this for pointer values 0x80 and 0x00 to reach the nested cases, and for 0x84 to reach indirect pointer loading. To show that a discarded write really changed nothing, the bench first fills every directly reachable location in both banks with a known pattern. After the pointer-driven clear loop, it sweeps the whole map and compares each location with its own model.

// File: rtl/iau_pkg.sv
package iau_pkg;
  // source of the registered read data
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_PTR  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/iau_resolve.sv
module iau_resolve #(
  parameter int DATA_W   = 8,
  parameter int DIR_W    = 7,
  parameter int IND_SLOT = 0,
  parameter int PTR_SLOT = 4,
  localparam int ADDR_W  = DATA_W + 1
) (
  input  logic [DIR_W-1:0]  file_addr,
  input  logic              bank_sel,
  input  logic [DATA_W-1:0] ptr_val,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              hit_ptr,
  output logic              nested
);
  localparam int PAD_W = DATA_W - DIR_W;

  logic              is_ind;
  logic [DIR_W-1:0]  low_bits;

  always_comb begin
    is_ind    = (file_addr == DIR_W'(IND_SLOT));
    phys_addr = is_ind ? {bank_sel, ptr_val}
                       : {bank_sel, {PAD_W{1'b0}}, file_addr};
    low_bits  = phys_addr[DIR_W-1:0];
    nested    = (low_bits == DIR_W'(IND_SLOT));
    hit_ptr   = (low_bits == DIR_W'(PTR_SLOT));
  end
endmodule

// File: rtl/iau_ptr_reg.sv
module iau_ptr_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= din;
  end

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ptr_q));
endmodule

// File: rtl/iau_regfile.sv
module iau_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-first, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end
endmodule

// File: rtl/ind_addr_unit.sv
module ind_addr_unit #(
  parameter int DATA_W   = 8,
  parameter int DIR_W    = 7,
  parameter int IND_SLOT = 0,
  parameter int PTR_SLOT = 4,
  localparam int ADDR_W  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIR_W-1:0]  file_addr,
  input  logic              bank_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_we
);
  import iau_pkg::*;

  logic [DATA_W-1:0] ptr_q;
  logic [ADDR_W-1:0] phys;
  logic              hit_ptr, nested;
  logic              arr_we, arr_re, ptr_ld;
  logic [DATA_W-1:0] mem_q;
  rd_src_e           src_q;
  logic [DATA_W-1:0] ptr_snap_q;

  iau_resolve #(
    .DATA_W(DATA_W), .DIR_W(DIR_W),
    .IND_SLOT(IND_SLOT), .PTR_SLOT(PTR_SLOT)
  ) u_res (
    .file_addr(file_addr), .bank_sel(bank_sel), .ptr_val(ptr_q),
    .phys_addr(phys), .hit_ptr(hit_ptr), .nested(nested)
  );

  always_comb begin
    arr_we = wr_en && !nested && !hit_ptr;
    arr_re = rd_en && !nested && !hit_ptr;
    ptr_ld = wr_en && hit_ptr;
  end

  iau_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_ld), .din(wr_data), .ptr_q(ptr_q)
  );

  iau_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .addr(phys), .we(arr_we), .re(arr_re),
    .wdata(wr_data), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q      <= SRC_ZERO;
      ptr_snap_q <= '0;
      rf_addr    <= '0;
      rf_we      <= 1'b0;
    end else begin
      rf_we <= arr_we;
      if (rd_en || wr_en) rf_addr <= phys;
      if (rd_en) begin
        ptr_snap_q <= ptr_q;
        if (nested)       src_q <= SRC_ZERO;
        else if (hit_ptr) src_q <= SRC_PTR;
        else              src_q <= SRC_MEM;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_MEM: rd_data = mem_q;
      SRC_PTR: rd_data = ptr_snap_q;
      default: rd_data = '0;
    endcase
  end

  // R2
  direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && file_addr != DIR_W'(IND_SLOT) && file_addr != DIR_W'(PTR_SLOT))
    |=> rf_addr == $past({bank_sel, {(DATA_W-DIR_W){1'b0}}, file_addr}));

  // R5
  nested_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && file_addr == DIR_W'(IND_SLOT) && ptr_q[DIR_W-1:0] == DIR_W'(IND_SLOT))
    |=> rd_data == '0);

  // R6
  nested_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && file_addr == DIR_W'(IND_SLOT) && ptr_q[DIR_W-1:0] == DIR_W'(IND_SLOT))
    |=> !rf_we);

  // R7
  ind_ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && file_addr == DIR_W'(IND_SLOT) && ptr_q[DIR_W-1:0] == DIR_W'(PTR_SLOT))
    |=> ptr_q == $past(wr_data));

  // R9
  no_virtual_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_addr[DIR_W-1:0] != DIR_W'(IND_SLOT) &&
               rf_addr[DIR_W-1:0] != DIR_W'(PTR_SLOT)));
endmodule

// File: tb/sim_ind_addr_unit.sv
`timescale 1ns/1ps
module sim_ind_addr_unit;
  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] file_addr = '0;
  logic       bank_sel = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [8:0] rf_addr;
  logic       rf_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  item_t sb[$];
  logic [7:0] model [512];
  logic [7:0] ptr_m;

  always #10 clk = ~clk;

  ind_addr_unit u0 (
    .clk(clk), .rst(rst), .file_addr(file_addr), .bank_sel(bank_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rf_addr(rf_addr), .rf_we(rf_we)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic b, input logic [6:0] fa, input logic r,
                    input logic w, input logic [7:0] wd);
    @(negedge clk);
    bank_sel = b; file_addr = fa; rd_en = r; wr_en = w; wr_data = wd;
    @(posedge clk);
  endtask

  task automatic do_rd(input logic b, input logic [6:0] fa,
                       input logic [7:0] exp, input string req);
    item_t it;
    it.exp = exp; it.req = req;
    sb.push_back(it);
    op(b, fa, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic do_wr(input logic b, input logic [6:0] fa, input logic [7:0] wd,
                       input logic exp_we, input logic [8:0] exp_addr, input string req);
    op(b, fa, 1'b0, 1'b1, wd);
    #5;
    chk(rf_we == exp_we, req, rf_we, exp_we);
    if (exp_we) chk(rf_addr == exp_addr, req, rf_addr, exp_addr);
  endtask

  // monitor: pops one expected item per read strobe
  initial begin
    forever begin
      logic r;
      @(posedge clk);
      r = rd_en;
      #5;
      if (r) begin
        if (sb.size() == 0) chk(1'b0, "scoreboard", 0, 1);
        else begin
          item_t it;
          it = sb.pop_front();
          chk(rd_data == it.exp, it.req, rd_data, it.exp);
        end
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(rf_we == 1'b0, "R1 rf_we", rf_we, 0);
    do_rd(1'b0, 7'h04, 8'h00, "R1 pointer");

    // fill directly reachable locations, R2 and R9
    for (int b = 0; b < 2; b++) begin
      for (int a = 1; a < 128; a++) begin
        logic [7:0] v;
        logic [8:0] pa;
        if (a == 4) continue;
        v  = 8'(a) ^ (b != 0 ? 8'hA5 : 8'h3C);
        pa = {1'(b), 1'b0, 7'(a)};
        model[pa] = v;
        do_wr(1'(b), 7'(a), v, 1'b1, pa, "R9 direct write");
      end
    end
    do_rd(1'b0, 7'h05, model[9'h005], "R2 bank0 read");
    do_rd(1'b1, 7'h05, model[9'h105], "R2 bank1 read");
    do_rd(1'b1, 7'h7F, model[9'h17F], "R2 top read");

    // R3 pointer through either bank
    do_wr(1'b1, 7'h04, 8'h20, 1'b0, 9'h0, "R3 pointer write");
    ptr_m = 8'h20;
    do_rd(1'b0, 7'h04, 8'h20, "R3 pointer read");

    // R4 indirect in both banks
    do_rd(1'b0, 7'h00, model[9'h020], "R4 bank0 indirect");
    do_rd(1'b1, 7'h00, model[9'h120], "R4 bank1 indirect");
    do_wr(1'b0, 7'h04, 8'h90, 1'b0, 9'h0, "R3 pointer write");
    do_wr(1'b1, 7'h00, 8'h6E, 1'b1, 9'h190, "R4 indirect write");
    do_rd(1'b1, 7'h00, 8'h6E, "R4 indirect readback");

    // R5 / R6 nested accesses
    do_wr(1'b0, 7'h04, 8'h80, 1'b0, 9'h0, "R3 pointer write");
    do_rd(1'b0, 7'h00, 8'h00, "R5 nested read 0x80");
    do_wr(1'b0, 7'h00, 8'h55, 1'b0, 9'h0, "R6 nested write 0x80");
    do_wr(1'b1, 7'h04, 8'h00, 1'b0, 9'h0, "R3 pointer write");
    do_rd(1'b1, 7'h00, 8'h00, "R5 nested read 0x00");
    do_wr(1'b1, 7'h00, 8'hAA, 1'b0, 9'h0, "R6 nested write 0x00");
    do_rd(1'b0, 7'h04, 8'h00, "R6 pointer untouched");

    // R7 indirect write onto the pointer
    do_wr(1'b0, 7'h04, 8'h84, 1'b0, 9'h0, "R3 pointer write");
    do_wr(1'b0, 7'h00, 8'h3A, 1'b0, 9'h0, "R7 no array write");
    do_rd(1'b1, 7'h04, 8'h3A, "R7 pointer loaded");

    // R8 read-first on simultaneous read and write
    begin
      item_t it;
      it.exp = model[9'h010]; it.req = "R8 old value";
      sb.push_back(it);
      op(1'b0, 7'h10, 1'b1, 1'b1, 8'hC3);
      model[9'h010] = 8'hC3;
    end
    do_rd(1'b0, 7'h10, 8'hC3, "R8 new value");

    // R10 clear loop
    ptr_m = 8'h40;
    do_wr(1'b0, 7'h04, ptr_m, 1'b0, 9'h0, "R10 pointer init");
    forever begin
      do_wr(1'b0, 7'h00, 8'h00, 1'b1, {1'b0, ptr_m}, "R10 indirect clear");
      model[{1'b0, ptr_m}] = 8'h00;
      do_rd(1'b0, 7'h04, ptr_m, "R10 pointer readback");
      ptr_m = ptr_m + 8'd1;
      do_wr(1'b0, 7'h04, ptr_m, 1'b0, 9'h0, "R10 pointer step");
      if (ptr_m == 8'h80) break;
    end
    for (int b = 0; b < 2; b++) begin
      for (int a = 1; a < 128; a++) begin
        if (a == 4) continue;
        do_rd(1'(b), 7'(a), model[{1'(b), 1'b0, 7'(a)}], "R10 sweep");
      end
    end
    do_rd(1'b1, 7'h04, 8'h80, "R10 final pointer");
    op(1'b0, 7'h00, 1'b0, 1'b0, 8'h00);
    op(1'b0, 7'h00, 1'b0, 1'b0, 8'h00);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule